// File: doc/BRIEF.md
# Program-Cycle Status Polling Responder

This block is the read path of a 16-bit word-wide flash model while an internal program cycle runs. A one-cycle `start` pulse marks the end of a word load. It captures the address and data of that word and opens a busy window of fixed length. During the window, reads do not return plain array contents. They return a status word that lets software find out when the cycle ends, by either of two methods.

The first method polls the last loaded address: bits 7 and 15 of the answer are the inverse of the loaded word's bits 7 and 15. The second method reads any address: bits 6 and 14 flip on every read. When the window closes, reads return the stored word again on all sixteen bits. If write protection is active when `start` arrives, the busy window and the status polling behave the same way, but the array is left untouched. This models a dummy write issued without the unlock sequence. The array sits behind a synchronous read port, so it maps onto block RAM.

Top module: `pgm_poll_responder`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `busy` is 0 and `rd_data` is 16'h0000.
- R2: A `start` sampled while `busy` is 0 makes `busy` 1 from the next cycle. `busy` then stays 1 for exactly `BUSY_CYCLES` clock cycles.
- R3: A `start` sampled while `busy` is 1 is ignored. It does not restart or lengthen the window, it does not replace the recorded last word, and it writes nothing into the array.
- R4: An accepted `start` with `protect` low stores `ld_data` at `ld_addr`. Once the window is over, that word reads back.
- R5: During the window, a read of the last loaded address returns bit 7 and bit 15 inverted with respect to the loaded word.
- R6: During the window, bits 6 and 14 of every read are equal. The first read after `start` gives 0 on both. Each later read inverts them. Clock cycles without `rd_en` leave the sequence unchanged.
- R7: During the window, every bit not named in R5 and R6 equals the corresponding bit of the word stored at the read address.
- R8: A read sampled on the first cycle with `busy` back at 0 returns the stored word on all 16 bits.
- R9: An accepted `start` with `protect` high runs the same busy window and status reads as R2, R5, R6 and R7, and leaves the array unchanged.
- R10: `rd_data` changes only on the cycle after a clock edge that sampled `rd_en` high. Otherwise it holds, whatever `rd_addr` does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse that ends a word load and requests a program cycle |
| protect | input | 1 | Write protection active; an accepted start becomes a dummy write |
| ld_addr | input | ADDR_W | Address of the loaded word |
| ld_data | input | 16 | Data of the loaded word |
| rd_en | input | 1 | Read strobe, one read per cycle it is high |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | 16 | Registered read result, stored word or status word |
| busy | output | 1 | Program cycle in progress |

## Verification
The bound checker watches several properties on every cycle. It checks the exact length of each busy window, and that a `start` inside a window neither restarts nor shortens it. It checks that `rd_data` holds when no read was sampled, and that bits 6 and 14 match on every status read. It also checks the inverted bits 7 and 15 against its own copy of the last accepted word. The bench scenarios cover the rest:

- the toggle sequence across reads that are not adjacent;
- the single cycle on which true data returns;
- mixing of polls at other addresses with array contents;
- the proof, by reading back after the window, that a protected or ignored load left the array unchanged.

// File: rtl/poll_pkg.sv
package poll_pkg;
  localparam int WORD_W = 16;
  // status bit positions in the returned word
  localparam int TGL_LO = 6;
  localparam int TGL_HI = 14;
  localparam int INV_LO = 7;
  localparam int INV_HI = 15;
  typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/poll_busy_timer.sv
module poll_busy_timer #(
  parameter int BUSY_CYCLES = 20
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic accept,
  output logic busy
);
  localparam int CNT_W = (BUSY_CYCLES > 1) ? $clog2(BUSY_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(BUSY_CYCLES - 1);

  logic [CNT_W-1:0] remain_q;

  assign accept = start & ~busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      remain_q <= '0;
    end else if (accept) begin
      busy     <= 1'b1;
      remain_q <= LOAD;
    end else if (busy) begin
      if (remain_q == '0) busy <= 1'b0;
      else                remain_q <= remain_q - 1'b1;
    end
  end
endmodule

// File: rtl/poll_word_array.sv
module poll_word_array
  import poll_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  word_t             wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output word_t             rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  word_t mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // read-first synchronous port with resettable output register
  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/poll_status_gen.sv
module poll_status_gen
  import poll_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic [ADDR_W-1:0] ld_addr,
  input  word_t             ld_data,
  input  logic              busy,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  word_t             raw_word,
  output word_t             rd_data
);
  logic [ADDR_W-1:0] last_addr_q;
  logic [1:0]        last_inv_q;
  logic              tgl_q;
  logic              s_busy_q, s_hit_q, s_tgl_q;
  logic [1:0]        s_inv_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      last_addr_q <= '0;
      last_inv_q  <= '0;
      tgl_q       <= 1'b0;
    end else if (accept) begin
      last_addr_q <= ld_addr;
      last_inv_q  <= ~{ld_data[INV_HI], ld_data[INV_LO]};
      tgl_q       <= 1'b0;
    end else if (rd_en && busy) begin
      tgl_q <= ~tgl_q;
    end
  end

  // snapshot of the status context taken with each read
  always_ff @(posedge clk) begin
    if (rst) begin
      s_busy_q <= 1'b0;
      s_hit_q  <= 1'b0;
      s_tgl_q  <= 1'b0;
      s_inv_q  <= '0;
    end else if (rd_en) begin
      s_busy_q <= busy;
      s_hit_q  <= busy && (rd_addr == last_addr_q);
      s_tgl_q  <= tgl_q;
      s_inv_q  <= last_inv_q;
    end
  end

  always_comb begin
    rd_data = raw_word;
    if (s_busy_q) begin
      rd_data[TGL_LO] = s_tgl_q;
      rd_data[TGL_HI] = s_tgl_q;
      if (s_hit_q) begin
        rd_data[INV_LO] = s_inv_q[0];
        rd_data[INV_HI] = s_inv_q[1];
      end
    end
  end
endmodule

// File: rtl/pgm_poll_responder.sv
module pgm_poll_responder
  import poll_pkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int BUSY_CYCLES = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              protect,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [15:0]       ld_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [15:0]       rd_data,
  output logic              busy
);
  logic  accept;
  word_t raw_word;

  poll_busy_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .accept (accept),
    .busy   (busy)
  );

  poll_word_array #(.ADDR_W(ADDR_W)) u_array (
    .clk   (clk),
    .rst   (rst),
    .we    (accept & ~protect),
    .waddr (ld_addr),
    .wdata (ld_data),
    .re    (rd_en),
    .raddr (rd_addr),
    .rdata (raw_word)
  );

  poll_status_gen #(.ADDR_W(ADDR_W)) u_status (
    .clk      (clk),
    .rst      (rst),
    .accept   (accept),
    .ld_addr  (ld_addr),
    .ld_data  (ld_data),
    .busy     (busy),
    .rd_en    (rd_en),
    .rd_addr  (rd_addr),
    .raw_word (raw_word),
    .rd_data  (rd_data)
  );
endmodule

// File: rtl/poll_responder_chk.sv
module poll_responder_chk #(
  parameter int ADDR_W      = 6,
  parameter int BUSY_CYCLES = 20
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              busy,
  input logic [ADDR_W-1:0] ld_addr,
  input logic [15:0]       ld_data,
  input logic              rd_en,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [15:0]       rd_data
);
  localparam int CNT_W = $clog2(BUSY_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BUSY_CYCLES - 1);

  logic [CNT_W-1:0]  len_q;
  logic [ADDR_W-1:0] ref_addr;
  logic [15:0]       ref_data;

  always_ff @(posedge clk) begin
    if (rst)       len_q <= '0;
    else if (busy) len_q <= len_q + 1'b1;
    else           len_q <= '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_addr <= '0;
      ref_data <= '0;
    end else if (start && !busy) begin
      ref_addr <= ld_addr;
      ref_data <= ld_data;
    end
  end

  AST_BUSY_RISE: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);  // R2
  AST_BUSY_BOUND: assert property (@(posedge clk) disable iff (rst)
    busy |-> (len_q <= LAST));  // R2
  AST_BUSY_LEN: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> ($past(len_q) == LAST));  // R2
  AST_NO_RESTART: assert property (@(posedge clk) disable iff (rst)
    (start && busy && len_q < LAST) |=> (busy && len_q == CNT_W'($past(len_q) + 1'b1)));  // R3
  AST_HOLD_DATA: assert property (@(posedge clk) disable iff (rst)
    (!$past(rd_en) && !$past(rst)) |-> $stable(rd_data));  // R10
  AST_TGL_PAIR: assert property (@(posedge clk) disable iff (rst)
    ($past(rd_en && busy) && !$past(rst)) |-> (rd_data[6] == rd_data[14]));  // R6
  AST_INV_BITS: assert property (@(posedge clk) disable iff (rst)
    ($past(rd_en && busy && rd_addr == ref_addr) && !$past(rst))
      |-> (rd_data[7] == ~$past(ref_data[7]) && rd_data[15] == ~$past(ref_data[15])));  // R5
endmodule

bind pgm_poll_responder poll_responder_chk #(
  .ADDR_W(ADDR_W), .BUSY_CYCLES(BUSY_CYCLES)
) u_chk (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .ld_addr(ld_addr),
  .ld_data(ld_data), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
);

// File: tb/pgm_poll_responder_tb.sv
module pgm_poll_responder_tb;
  localparam int AW = 6;
  localparam int BC = 20;
  localparam int W  = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0, protect = 1'b0, rd_en = 1'b0;
  logic [AW-1:0] ld_addr = '0, rd_addr = '0;
  logic [W-1:0]  ld_data = '0;
  logic [W-1:0]  rd_data;
  logic          busy;

  int n_cmp = 0, n_bad = 0;

  logic [W-1:0]  mem_m [1<<AW];
  logic [AW-1:0] last_a;
  logic [W-1:0]  last_d;
  logic          tog_m;

  // {protect, addr[2:0], data[15:0]}
  localparam logic [19:0] VEC [6] = '{
    {1'b0, 3'd2, 16'h1234},
    {1'b0, 3'd5, 16'h80FF},
    {1'b1, 3'd2, 16'hFFFF},
    {1'b0, 3'd7, 16'h0080},
    {1'b1, 3'd0, 16'h5A5A},
    {1'b0, 3'd0, 16'h8000}
  };

  always #4 clk = ~clk;

  pgm_poll_responder #(.ADDR_W(AW), .BUSY_CYCLES(BC)) u_dut (
    .clk(clk), .rst(rst), .start(start), .protect(protect),
    .ld_addr(ld_addr), .ld_data(ld_data), .rd_en(rd_en),
    .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy)
  );

  task automatic report();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // all tasks start at a falling edge and end at one
  task automatic do_start(input logic p, input logic [AW-1:0] a, input logic [W-1:0] d);
    start = 1'b1; protect = p; ld_addr = a; ld_data = d;
    @(negedge clk);
    start = 1'b0; protect = 1'b0;
    last_a = a; last_d = d; tog_m = 1'b0;
    if (!p) mem_m[a] = d;
  endtask

  task automatic do_read(input logic [AW-1:0] a, output logic [W-1:0] q);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    q = rd_data;
  endtask

  function automatic logic [W-1:0] exp_poll(input logic [AW-1:0] a);
    logic [W-1:0] w;
    w = mem_m[a];
    if (a == last_a) begin
      w[7]  = ~last_d[7];
      w[15] = ~last_d[15];
    end
    w[6]  = tog_m;
    w[14] = tog_m;
    return w;
  endfunction

  task automatic poll(input logic [AW-1:0] a, input string req);
    logic [W-1:0] q;
    do_read(a, q);
    chk(req, q, exp_poll(a));
    tog_m = ~tog_m;
  endtask

  task automatic true_read(input logic [AW-1:0] a, input string req);
    logic [W-1:0] q;
    do_read(a, q);
    chk(req, q, mem_m[a]);
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
    report();
    $finish;
  end

  initial begin
    logic [W-1:0] hold_v;
    repeat (3) @(negedge clk);
    // R1: reset state while held and right after release
    chk("R1 busy in reset", {15'd0, busy}, 16'd0);
    chk("R1 rd_data in reset", rd_data, 16'h0000);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 busy after reset", {15'd0, busy}, 16'd0);
    chk("R1 rd_data after reset", rd_data, 16'h0000);

    // preload addresses 0..7 (unprotected)
    for (int a = 0; a < 8; a++) begin
      do_start(1'b0, AW'(a), (16'h0101 * 16'(a)) ^ 16'hA5C3);
      repeat (BC) @(negedge clk);
    end
    for (int a = 0; a < 8; a++) true_read(AW'(a), "R4 preload readback");

    // table walk: polls alternate last address / neighbour
    foreach (VEC[i]) begin
      logic          p;
      logic [AW-1:0] a, o;
      p = VEC[i][19];
      a = AW'(VEC[i][18:16]);
      o = a ^ AW'(1);
      do_start(p, a, VEC[i][15:0]);
      for (int k = 0; k < BC; k++) begin
        if (k == BC - 1) chk("R2 busy on last window cycle", {15'd0, busy}, 16'd1);
        poll((k % 2 == 1) ? o : a, p ? "R9 R5 R6 R7 protected poll" : "R5 R6 R7 poll");
      end
      chk("R2 busy low after window", {15'd0, busy}, 16'd0);
      true_read(a, p ? "R9 array unchanged" : "R8 R4 true data first idle cycle");
      true_read(o, "R8 neighbour true data");
    end

    // R3: start during busy is ignored; R6 idle cycle leaves toggle alone
    do_start(1'b0, AW'(4), 16'h7E81);
    for (int k = 0; k < 3; k++) poll(AW'(4), "R5 R6 poll before ignored start");
    start = 1'b1; ld_addr = AW'(6); ld_data = 16'hDEAD;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < BC - 4; k++) poll(AW'(4), "R3 R6 poll after ignored start");
    chk("R3 window not extended", {15'd0, busy}, 16'd0);
    true_read(AW'(6), "R3 no write from ignored start");
    true_read(AW'(4), "R8 true data after window");

    // R10: output holds without rd_en
    do_read(AW'(2), hold_v);
    rd_addr = AW'(5);
    repeat (3) @(negedge clk);
    chk("R10 hold without read", rd_data, hold_v);

    // R6: toggle does not advance on non-read cycles
    do_start(1'b1, AW'(3), 16'h0000);
    poll(AW'(3), "R6 first read gives 0");
    repeat (2) @(negedge clk);
    poll(AW'(1), "R6 after idle cycles");
    poll(AW'(3), "R6 third read");
    repeat (BC) @(negedge clk);
    true_read(AW'(3), "R9 protected word unchanged");

    report();
    $finish;
  end
endmodule